// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a synchronous three-bit counter whose bits are named C (most significant), B and A (least significant). While its count enable is high it advances on every rising clock edge through a fixed, non-binary cycle of five codes. While the enable is low it holds its code.

The other three codes are not part of the cycle. A counter that finds itself in one of them, for example after an upset or a power-up with no reset, returns to the cycle on the next enabled edge. It never passes through two unused codes in a row.

The storage element is chosen by a parameter: plain data flops, toggle flops, JK flops or set/reset flops. Each choice has its own excitation logic, and all four give the same sequence at the output. A second parameter sets the code that the active-low synchronous reset loads. It is 000 by default. Setting it to an unused code gives a clean way to start the counter outside the cycle.

Top module: `scnt5_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state loads RESET_CODE (default 000) at that edge.
- R2: With cnt_en high and no reset, an edge moves the state one step along the cycle 000 → 010 → 011 → 101 → 110 → 000. Codes are written C B A, with C as state_o[2] and A as state_o[0].
- R3: With cnt_en high and no reset, an edge moves the unused codes as follows: 001 goes to 110, 100 goes to 010 and 111 goes to 101.
- R4: From any of the eight codes, one enabled edge leaves the state at one of the five cycle codes.
- R5: With cnt_en low and no reset, an edge leaves the state unchanged, including when the state is an unused code.
- R6: STORAGE values 0 (data flop), 1 (toggle flop), 2 (JK flop) and 3 (set/reset flop) give the same state_o sequence for the same inputs and the same RESET_CODE.
- R7: Reset takes priority over the count enable: a reset edge with cnt_en high still loads RESET_CODE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset, loads RESET_CODE |
| cnt_en | input | 1 | Advance on the next edge when high; hold when low |
| state_o | output | 3 | Registered state, bit 2 = C, bit 1 = B, bit 0 = A |

## Verification
Each result is due at the first rising edge after its inputs are applied. This holds for an advance, a hold, a recovery from an unused code and a reset load, because there is exactly one register between the inputs and state_o. The bench changes cnt_en and rst_n on a falling edge and compares state_o at the next falling edge, so exactly one rising edge lies between stimulus and sample. The bench also builds a grid of instances, one for every storage kind and every reset code. A bench-side model predicts each instance one edge ahead, so all eight start codes are followed through recovery and into the cycle under the same sampling rule.

// File: rtl/scnt5_pkg.sv
package scnt5_pkg;

    localparam int STATE_W = 3;

    // storage element kinds
    localparam int KIND_D  = 0;
    localparam int KIND_T  = 1;
    localparam int KIND_JK = 2;
    localparam int KIND_RS = 3;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } code_t;

endpackage

// File: rtl/scnt5_next.sv
// Target code for the next enabled edge, over all eight present codes.
module scnt5_next
    import scnt5_pkg::*;
(
    input  code_t cur_i,
    output code_t tgt_o
);
    always_comb begin
        tgt_o   = '0;
        // C follows A in every code, used or not
        tgt_o.c = cur_i.a;
        // B sets unless B was set, except from 010 where it stays set
        tgt_o.b = ~cur_i.b | (~cur_i.a & ~cur_i.c);
        // A sets only from 010, 011 and 111
        tgt_o.a = cur_i.b & (~cur_i.c | cur_i.a);
    end
endmodule

// File: rtl/scnt5_excite.sv
// Converts present and target codes into the two inputs of the chosen flop kind.
// x carries D, T, J or S; y carries K or R (held low for D and T kinds).
module scnt5_excite
    import scnt5_pkg::*;
#(
    parameter int KIND = KIND_D
) (
    input  logic               en_i,
    input  logic [STATE_W-1:0] cur_i,
    input  logic [STATE_W-1:0] tgt_i,
    output logic [STATE_W-1:0] x_o,
    output logic [STATE_W-1:0] y_o
);
    generate
        if (KIND == KIND_D) begin : g_d
            always_comb begin
                x_o = en_i ? tgt_i : cur_i;
                y_o = '0;
            end
        end else if (KIND == KIND_T) begin : g_t
            always_comb begin
                x_o = en_i ? (cur_i ^ tgt_i) : '0;
                y_o = '0;
            end
        end else if (KIND == KIND_JK) begin : g_jk
            always_comb begin
                x_o = {STATE_W{en_i}} & tgt_i;
                y_o = {STATE_W{en_i}} & ~tgt_i;
            end
        end else begin : g_rs
            always_comb begin
                x_o = {STATE_W{en_i}} & tgt_i & ~cur_i;
                y_o = {STATE_W{en_i}} & ~tgt_i & cur_i;
            end
        end
    endgenerate
endmodule

// File: rtl/scnt5_store.sv
// Bank of flops of the chosen kind with synchronous reset to a fixed code.
module scnt5_store
    import scnt5_pkg::*;
#(
    parameter int                 KIND       = KIND_D,
    parameter logic [STATE_W-1:0] RESET_CODE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] x_i,
    input  logic [STATE_W-1:0] y_i,
    output logic [STATE_W-1:0] q_o
);
    logic [STATE_W-1:0] q_d;
    logic [STATE_W-1:0] q_q;

    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        if (KIND == KIND_D) begin : g_d
            // y acts as a clear input; excitation keeps it low
            always_comb q_d[i] = x_i[i] & ~y_i[i];
        end else if (KIND == KIND_T) begin : g_t
            always_comb q_d[i] = (q_q[i] ^ x_i[i]) & ~y_i[i];
        end else if (KIND == KIND_JK) begin : g_jk
            always_comb q_d[i] = (x_i[i] & ~q_q[i]) | (~y_i[i] & q_q[i]);
        end else begin : g_rs
            always_comb q_d[i] = x_i[i] | (~y_i[i] & q_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= RESET_CODE;
        else        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/scnt5_top.sv
module scnt5_top
    import scnt5_pkg::*;
#(
    parameter int                 STORAGE    = KIND_D,
    parameter logic [STATE_W-1:0] RESET_CODE = 3'b000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    output logic [STATE_W-1:0] state_o
);
    code_t              cur_q;
    code_t              tgt_d;
    logic [STATE_W-1:0] x_d;
    logic [STATE_W-1:0] y_d;

    scnt5_next u_next (
        .cur_i (cur_q),
        .tgt_o (tgt_d)
    );

    scnt5_excite #(.KIND(STORAGE)) u_excite (
        .en_i  (cnt_en),
        .cur_i (cur_q),
        .tgt_i (tgt_d),
        .x_o   (x_d),
        .y_o   (y_d)
    );

    logic [STATE_W-1:0] q_raw;

    scnt5_store #(.KIND(STORAGE), .RESET_CODE(RESET_CODE)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (x_d),
        .y_i   (y_d),
        .q_o   (q_raw)
    );

    assign cur_q   = code_t'(q_raw);
    assign state_o = q_raw;
endmodule

// File: rtl/scnt5_chk.sv
module scnt5_chk #(
    parameter logic [2:0] RESET_CODE = 3'b000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic [2:0] state_o
);
    function automatic logic in_cycle(input logic [2:0] v);
        return (v == 3'b000) || (v == 3'b010) || (v == 3'b011) ||
               (v == 3'b101) || (v == 3'b110);
    endfunction

    function automatic logic [2:0] step_of(input logic [2:0] v);
        case (v)
            3'b000:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b110;
            3'b110:  return 3'b000;
            3'b001:  return 3'b110;
            3'b100:  return 3'b010;
            default: return 3'b101;
        endcase
    endfunction

    assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && in_cycle(state_o)) |=> (state_o == step_of($past(state_o))));

    assert_unused_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !in_cycle(state_o)) |=> (state_o == step_of($past(state_o))));

    assert_rejoin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> in_cycle(state_o));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(state_o));

    logic rst_prev_q;
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    // R1, R7: a reset edge, enabled or not, leaves RESET_CODE
    always @(negedge clk) begin
        if (rst_prev_q === 1'b1) begin
            assert_reset_load_R1: assert (state_o == RESET_CODE);
        end
    end
endmodule

bind scnt5_top scnt5_chk #(.RESET_CODE(RESET_CODE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .state_o (state_o)
);

// File: tb/scnt5_top_tb_top.sv
`timescale 1ns/100ps
module scnt5_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic [2:0] state_o;
    logic [2:0] grid_q [4][8];
    logic [2:0] grid_exp [4][8];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scnt5_top dut_i (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .state_o(state_o));

    for (genvar k = 0; k < 4; k++) begin : g_kind
        for (genvar r = 0; r < 8; r++) begin : g_rst
            scnt5_top #(.STORAGE(k), .RESET_CODE(3'(r))) u_cnt (
                .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .state_o(grid_q[k][r]));
        end
    end

    // {cnt_en, expected state of dut_i after the edge}
    localparam logic [3:0] WALK [16] = '{
        4'b1_010, 4'b1_011, 4'b0_011, 4'b1_101, 4'b1_110, 4'b1_000, 4'b0_000, 4'b0_000,
        4'b1_010, 4'b1_011, 4'b1_101, 4'b0_101, 4'b1_110, 4'b1_000, 4'b1_010, 4'b0_010};

    function automatic logic [2:0] model_next(input logic [2:0] v);
        case (v)
            3'b000:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b110;
            3'b110:  return 3'b000;
            3'b001:  return 3'b110;
            3'b100:  return 3'b010;
            default: return 3'b101;
        endcase
    endfunction

    function automatic logic is_cycle(input logic [2:0] v);
        return v inside {3'b000, 3'b010, 3'b011, 3'b101, 3'b110};
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic en, input logic rst);
        cnt_en = en;
        rst_n  = rst;
        @(negedge clk);
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < 8; r++)
                if (!rst)    grid_exp[k][r] = 3'(r);
                else if (en) grid_exp[k][r] = model_next(grid_exp[k][r]);
    endtask

    task automatic check_grid(input string tag);
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < 8; r++)
                check(tag, grid_q[k][r], grid_exp[k][r]);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset loads each instance's code
        step(1'b0, 1'b0);
        check("R1 reset dut", state_o, 3'b000);
        check_grid("R1 reset grid");
        // R7: reset with enable high
        step(1'b1, 1'b0);
        check("R7 reset over enable", state_o, 3'b000);
        check_grid("R7 reset over enable grid");
        // R5: hold, including unused codes
        step(1'b0, 1'b1);
        check("R5 hold dut", state_o, 3'b000);
        check("R5 hold unused 001", grid_q[0][1], 3'b001);
        check("R5 hold unused 111 rs", grid_q[3][7], 3'b111);
        check_grid("R5 hold grid");
        // R3, R4: one enabled edge from every start code
        step(1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            check("R3 001->110", grid_q[k][1], 3'b110);
            check("R3 100->010", grid_q[k][4], 3'b010);
            check("R3 111->101", grid_q[k][7], 3'b101);
            for (int r = 0; r < 8; r++)
                check("R4 in cycle after one edge", 3'(is_cycle(grid_q[k][r])), 3'b001);
        end
        check_grid("R6 first step grid");
        // R2, R6: table walk from reset
        step(1'b0, 1'b0);
        check("R1 re-reset", state_o, 3'b000);
        for (int i = 0; i < 16; i++) begin
            step(WALK[i][3], 1'b1);
            check("R2 walk", state_o, WALK[i][2:0]);
            check_grid("R6 walk grid");
        end
        // R7: reset mid-cycle with enable high
        step(1'b1, 1'b1);
        check("R2 pre-reset step", state_o, 3'b011);
        step(1'b1, 1'b0);
        check("R7 mid-cycle reset", state_o, 3'b000);
        check_grid("R7 mid-cycle reset grid");
        // R2: full lap twice
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b1);
            check_grid("R2 lap grid");
        end
        check("R2 two laps back to 000", state_o, 3'b000);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule